// File: doc/BRIEF.md
# Descriptor-Chained Copy Channel

This block is a memory-to-memory copy channel. A host controls it through a small register file. The host writes the address of the first descriptor and sets the enable bit. The channel then reads descriptors from memory, one after another, and copies the data each one describes.

Each descriptor is seven 32-bit words at ascending addresses:

| Word | Contents |
|---|---|
| 0 | Link to the next descriptor |
| 1 | Source address |
| 2 | Upper source address |
| 3 | Destination address |
| 4 | Byte count |
| 5 | Control word |
| 6 | Checksum address (read and discarded) |

A link of zero ends the chain. The channel then parks and waits for more work. The host can add descriptors to a chain that has gone idle and issue an append command, and the channel picks up where it stopped.

The data engine moves one 32-bit word at a time over a generic request/acknowledge memory port. Every completed descriptor sets an end-of-transfer flag. Each status event has its own write-one-to-clear flag. A single interrupt line reflects the pending events.

Top module: `desc_dma_chan`

## Requirements
- R1: After reset, every register reads 0, the interrupt output is 0 and no memory request is made.
- R2: Setting control bit 0 (enable) while it is 0 loads the current-descriptor register (offset 0x0C) from the next-descriptor register (offset 0x10). The channel then reads the seven descriptor words at current, +4, …, +24. Their fields read back at 0x14 (source), 0x18 (upper source), 0x1C (destination), 0x20 (byte count) and 0x24 (control).
- R3: For a nonzero byte count, the channel reads a word from the source and writes it to the destination, count/4 times, at ascending addresses. After each write the source and destination advance by 4 and the byte count drops by 4.
- R4: After a descriptor, a nonzero link causes the next descriptor to be fetched. A zero link sets status bit 8 (end of chain) and returns the channel to idle. Enabling with a zero next-descriptor register sets bit 8 without any memory access.
- R5: Status bit 10 reads 1 exactly while the channel is working, and no memory request is made while it reads 0.
- R6: Every descriptor that completes sets status bit 9 (end of transfer). The interrupt output rises only if bit 4 (interrupt enable) of that descriptor's control word is 1.
- R7: Writing the status register clears each flag written as 1 and leaves the other flags unchanged. Clearing bit 9 withdraws the interrupt caused by descriptor completion. The interrupt output is the OR of that pending completion and the error flags.
- R8: A descriptor with byte count 0 completes with no data access: it costs exactly its seven fetch reads.
- R9: Writing control with bits 1:0 = 11 while the channel is enabled and idle re-reads the link word of the current descriptor and continues from it if it is nonzero. The same write while busy is remembered and acted on when the chain ends. Bit 1 always reads 0.
- R10: Before copying, the channel checks the descriptor in priority order. A byte count above 16 MiB sets bit 1. Otherwise a control word with bit 6 (memory-to-memory) at 0 sets bit 2. Otherwise a source, destination or count that is not a multiple of 4 sets bit 3. An error blocks all data access, clears enable and idles the channel.
- R11: A memory error returned with an acknowledge sets status bit 5, stops the channel at once and clears enable.
- R12: Clearing enable while busy lets the current descriptor finish, including its end-of-transfer flag. The channel then idles without following the link and without setting end of chain.
- R13: A memory request that has not been acknowledged stays asserted with its address and direction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Host register write strobe |
| regAddr | input | 8 | Host register byte offset |
| regWdata | input | 32 | Host write data |
| regRdata | output | 32 | Host read data for regAddr (combinational) |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory acknowledge |
| memErr | input | 1 | Memory error, valid with memAck |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle:
- pending memory requests stay stable;
- the channel is silent on the memory port while it reports idle;
- every acknowledged data write steps the source and count by one word;
- every new error flag leaves the channel idle;
- the interrupt always has a flag behind it.

Other behaviour shows up only across whole scenarios:
- the order of descriptor words;
- chain following and termination;
- resuming by append, both when idle and when the append was posted while busy;
- the error check priority;
- a disable that lets a descriptor finish;
- the exact number of memory accesses for zero-length descriptors.

The bench's directed tests check these by counting accesses and inspecting memory and registers.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int LOW_BITS   = $clog2(WORD_BYTES);
  localparam int DESC_WORDS = 7;
  localparam int IDX_W      = $clog2(DESC_WORDS + 1);

  // host register byte offsets
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CUR  = 8'h0C;
  localparam logic [7:0] OFS_NEXT = 8'h10;
  localparam logic [7:0] OFS_SRC  = 8'h14;
  localparam logic [7:0] OFS_USRC = 8'h18;
  localparam logic [7:0] OFS_DST  = 8'h1C;
  localparam logic [7:0] OFS_CNT  = 8'h20;
  localparam logic [7:0] OFS_DCTL = 8'h24;

  // status bit positions
  localparam int ST_BUSY  = 10;
  localparam int ST_EOT   = 9;
  localparam int ST_EOC   = 8;
  localparam int ST_MEM   = 5;
  localparam int ST_ALIGN = 3;
  localparam int ST_TYPE  = 2;
  localparam int ST_SIZE  = 1;

  // descriptor control word bits
  localparam int DC_INTEN = 4;
  localparam int DC_M2M   = 6;

  typedef enum logic [1:0] {
    ADR_DESC,
    ADR_PTR,
    ADR_SRC,
    ADR_DST
  } addrSel_e;

  typedef struct packed {
    logic     loadBase;
    logic     capWord;
    logic     capPtr;
    logic     capData;
    logic     advance;
    addrSel_e addrSel;
  } dpStrobe_t;

  typedef struct packed {
    logic ndaZero;
    logic curZero;
    logic cntZero;
    logic cntLast;
    logic wordLast;
    logic errSize;
    logic errType;
    logic errAlign;
    logic intEn;
  } dpFlags_t;

  // error flag vector order: size, type, align, mem
  localparam int ERR_N = 4;

endpackage

// File: rtl/dma_chan_dpath.sv
module dma_chan_dpath
  import dma_chan_pkg::*;
#(
  parameter int          REG_ADDR_W = 8,
  parameter logic [31:0] MAX_BYTES  = 32'h0100_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic [WORD_W-1:0]     memRdata,
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0]     regWdata,
  input  logic                  busy,
  input  logic [WORD_W-1:0]     ctrlWord,
  input  logic [WORD_W-1:0]     statusWord,
  output logic [WORD_W-1:0]     memAddr,
  output logic [WORD_W-1:0]     memWdata,
  output logic [WORD_W-1:0]     regRdata,
  output dpFlags_t              flags,
  output logic [WORD_W-1:0]     cntVal,
  output logic [WORD_W-1:0]     srcVal
);

  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_BYTES);

  logic [WORD_W-1:0] ndaQ, curQ, srcQ, usrcQ, dstQ, cntQ, dctlQ, bufQ;
  logic [IDX_W-1:0]  idxQ;
  logic              ndaHostWr;

  assign ndaHostWr = regWe && (regAddr == REG_ADDR_W'(OFS_NEXT)) && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ndaQ  <= '0;
      curQ  <= '0;
      srcQ  <= '0;
      usrcQ <= '0;
      dstQ  <= '0;
      cntQ  <= '0;
      dctlQ <= '0;
      bufQ  <= '0;
      idxQ  <= '0;
    end else begin
      if (ndaHostWr) ndaQ <= regWdata;
      if (strb.loadBase) begin
        curQ <= ndaQ;
        idxQ <= '0;
      end
      if (strb.capPtr) ndaQ <= memRdata;
      if (strb.capWord) begin
        case (idxQ)
          IDX_W'(0): ndaQ  <= memRdata;
          IDX_W'(1): srcQ  <= memRdata;
          IDX_W'(2): usrcQ <= memRdata;
          IDX_W'(3): dstQ  <= memRdata;
          IDX_W'(4): cntQ  <= memRdata;
          IDX_W'(5): dctlQ <= memRdata;
          default: ;
        endcase
        idxQ <= idxQ + IDX_W'(1);
      end
      if (strb.capData) bufQ <= memRdata;
      if (strb.advance) begin
        srcQ <= srcQ + STEP;
        dstQ <= dstQ + STEP;
        cntQ <= cntQ - STEP;
      end
    end
  end

  always_comb begin
    case (strb.addrSel)
      ADR_DESC: memAddr = curQ + (WORD_W'(idxQ) << LOW_BITS);
      ADR_PTR:  memAddr = curQ;
      ADR_SRC:  memAddr = srcQ;
      default:  memAddr = dstQ;
    endcase
  end

  assign memWdata = bufQ;

  assign flags.ndaZero  = (ndaQ == '0);
  assign flags.curZero  = (curQ == '0);
  assign flags.cntZero  = (cntQ == '0);
  assign flags.cntLast  = (cntQ == STEP);
  assign flags.wordLast = (idxQ == IDX_W'(DESC_WORDS - 1));
  assign flags.errSize  = (cntQ > MAX_BYTES);
  assign flags.errType  = !dctlQ[DC_M2M];
  assign flags.errAlign = |{srcQ[LOW_BITS-1:0], dstQ[LOW_BITS-1:0], cntQ[LOW_BITS-1:0]};
  assign flags.intEn    = dctlQ[DC_INTEN];

  always_comb begin
    case (regAddr)
      REG_ADDR_W'(OFS_CTRL): regRdata = ctrlWord;
      REG_ADDR_W'(OFS_STAT): regRdata = statusWord;
      REG_ADDR_W'(OFS_CUR):  regRdata = curQ;
      REG_ADDR_W'(OFS_NEXT): regRdata = ndaQ;
      REG_ADDR_W'(OFS_SRC):  regRdata = srcQ;
      REG_ADDR_W'(OFS_USRC): regRdata = usrcQ;
      REG_ADDR_W'(OFS_DST):  regRdata = dstQ;
      REG_ADDR_W'(OFS_CNT):  regRdata = cntQ;
      REG_ADDR_W'(OFS_DCTL): regRdata = dctlQ;
      default:               regRdata = '0;
    endcase
  end

  assign cntVal = cntQ;
  assign srcVal = srcQ;

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [1:0]        ctrlBits,
  input  logic              statWr,
  input  logic [5:0]        clrBits,
  input  logic              memAck,
  input  logic              memErr,
  input  dpFlags_t          flags,
  output dpStrobe_t         strb,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [WORD_W-1:0] statusWord,
  output logic              busy,
  output logic              irq
);

  // clrBits order: {eot, eoc, mem, align, type, size}
  typedef enum logic [2:0] {
    S_IDLE, S_LINK, S_RDPTR, S_FETCH, S_CHECK, S_RD, S_WR, S_DONE
  } state_e;

  state_e           stateQ, stateD;
  logic             enQ, appPendQ, eotQ, eocQ, irqPendQ;
  logic [ERR_N-1:0] errQ, setErr, errClr;
  logic             setEot, setEoc, clrAppend, haltEn, kick, ackErr, ackOk;

  assign kick   = ctrlWr && ctrlBits[0] && (!enQ || ctrlBits[1]);
  assign ackErr = memAck && memErr;
  assign ackOk  = memAck && !memErr;
  assign errClr = statWr ? {clrBits[3], clrBits[2], clrBits[1], clrBits[0]} : '0;

  always_comb begin
    stateD       = stateQ;
    strb         = '0;
    strb.addrSel = ADR_DESC;
    memReq       = 1'b0;
    memWe        = 1'b0;
    setEot       = 1'b0;
    setEoc       = 1'b0;
    setErr       = '0;
    clrAppend    = 1'b0;
    haltEn       = 1'b0;
    case (stateQ)
      S_IDLE: begin
        if (kick) stateD = (!enQ || flags.curZero) ? S_LINK : S_RDPTR;
      end
      S_LINK: begin
        if (!enQ) begin
          stateD = S_IDLE;
        end else if (flags.ndaZero) begin
          setEoc = 1'b1;
          if (appPendQ) begin
            clrAppend = 1'b1;
            stateD    = S_RDPTR;
          end else begin
            stateD = S_IDLE;
          end
        end else begin
          strb.loadBase = 1'b1;
          stateD        = S_FETCH;
        end
      end
      S_RDPTR: begin
        memReq       = 1'b1;
        strb.addrSel = ADR_PTR;
        if (ackOk) begin
          strb.capPtr = 1'b1;
          stateD      = S_LINK;
        end
      end
      S_FETCH: begin
        memReq       = 1'b1;
        strb.addrSel = ADR_DESC;
        if (ackOk) begin
          strb.capWord = 1'b1;
          if (flags.wordLast) stateD = S_CHECK;
        end
      end
      S_CHECK: begin
        if (flags.errSize) begin
          setErr[0] = 1'b1;
          haltEn    = 1'b1;
          stateD    = S_IDLE;
        end else if (flags.errType) begin
          setErr[1] = 1'b1;
          haltEn    = 1'b1;
          stateD    = S_IDLE;
        end else if (flags.errAlign) begin
          setErr[2] = 1'b1;
          haltEn    = 1'b1;
          stateD    = S_IDLE;
        end else if (flags.cntZero) begin
          stateD = S_DONE;
        end else begin
          stateD = S_RD;
        end
      end
      S_RD: begin
        memReq       = 1'b1;
        strb.addrSel = ADR_SRC;
        if (ackOk) begin
          strb.capData = 1'b1;
          stateD       = S_WR;
        end
      end
      S_WR: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.addrSel = ADR_DST;
        if (ackOk) begin
          strb.advance = 1'b1;
          stateD       = flags.cntLast ? S_DONE : S_RD;
        end
      end
      S_DONE: begin
        setEot = 1'b1;
        stateD = S_LINK;
      end
      default: stateD = S_IDLE;
    endcase
    if (memReq && ackErr) begin
      setErr[3]    = 1'b1;
      haltEn       = 1'b1;
      stateD       = S_IDLE;
      strb.capPtr  = 1'b0;
      strb.capWord = 1'b0;
      strb.capData = 1'b0;
      strb.advance = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      enQ      <= 1'b0;
      appPendQ <= 1'b0;
      eotQ     <= 1'b0;
      eocQ     <= 1'b0;
      irqPendQ <= 1'b0;
      errQ     <= '0;
    end else begin
      stateQ <= stateD;
      if (haltEn) enQ <= 1'b0;
      else if (ctrlWr) enQ <= ctrlBits[0];
      if (haltEn || (ctrlWr && !ctrlBits[0])) appPendQ <= 1'b0;
      else if (ctrlWr && ctrlBits[1] && enQ && (stateQ != S_IDLE)) appPendQ <= 1'b1;
      else if (clrAppend) appPendQ <= 1'b0;
      eotQ     <= setEot | (eotQ & ~(statWr & clrBits[5]));
      eocQ     <= setEoc | (eocQ & ~(statWr & clrBits[4]));
      irqPendQ <= (setEot & flags.intEn) | (irqPendQ & ~(statWr & clrBits[5]));
      errQ     <= setErr | (errQ & ~errClr);
    end
  end

  assign busy = (stateQ != S_IDLE);
  assign irq  = irqPendQ | (|errQ);

  always_comb begin
    ctrlWord    = '0;
    ctrlWord[0] = enQ;
    statusWord           = '0;
    statusWord[ST_BUSY]  = busy;
    statusWord[ST_EOT]   = eotQ;
    statusWord[ST_EOC]   = eocQ;
    statusWord[ST_MEM]   = errQ[3];
    statusWord[ST_ALIGN] = errQ[2];
    statusWord[ST_TYPE]  = errQ[1];
    statusWord[ST_SIZE]  = errQ[0];
  end

endmodule

// File: rtl/desc_dma_chan.sv
module desc_dma_chan
  import dma_chan_pkg::*;
#(
  parameter int          REG_ADDR_W = 8,
  parameter logic [31:0] MAX_BYTES  = 32'h0100_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0]     regWdata,
  output logic [WORD_W-1:0]     regRdata,
  output logic                  memReq,
  output logic                  memWe,
  output logic [WORD_W-1:0]     memAddr,
  output logic [WORD_W-1:0]     memWdata,
  input  logic [WORD_W-1:0]     memRdata,
  input  logic                  memAck,
  input  logic                  memErr,
  output logic                  irq
);

  dpStrobe_t         strb;
  dpFlags_t          flags;
  logic [WORD_W-1:0] ctrlWord, statusWord, cntVal, srcVal;
  logic              busy, ctrlWr, statWr;
  logic [5:0]        clrBits;

  assign ctrlWr  = regWe && (regAddr == REG_ADDR_W'(OFS_CTRL));
  assign statWr  = regWe && (regAddr == REG_ADDR_W'(OFS_STAT));
  assign clrBits = {regWdata[ST_EOT], regWdata[ST_EOC], regWdata[ST_MEM],
                    regWdata[ST_ALIGN], regWdata[ST_TYPE], regWdata[ST_SIZE]};

  dma_chan_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWr    (ctrlWr),
    .ctrlBits  (regWdata[1:0]),
    .statWr    (statWr),
    .clrBits   (clrBits),
    .memAck    (memAck),
    .memErr    (memErr),
    .flags     (flags),
    .strb      (strb),
    .memReq    (memReq),
    .memWe     (memWe),
    .ctrlWord  (ctrlWord),
    .statusWord(statusWord),
    .busy      (busy),
    .irq       (irq)
  );

  dma_chan_dpath #(
    .REG_ADDR_W(REG_ADDR_W),
    .MAX_BYTES (MAX_BYTES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .memRdata  (memRdata),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .busy      (busy),
    .ctrlWord  (ctrlWord),
    .statusWord(statusWord),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .regRdata  (regRdata),
    .flags     (flags),
    .cntVal    (cntVal),
    .srcVal    (srcVal)
  );

endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker
  import dma_chan_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic              memErr,
  input logic [WORD_W-1:0] memAddr,
  input logic              irq,
  input logic [WORD_W-1:0] statusWord,
  input logic [WORD_W-1:0] cntVal,
  input logic [WORD_W-1:0] srcVal
);

  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_BYTES);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R13

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[ST_BUSY] |-> !memReq); // R5

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck && !memErr) |=> (cntVal == $past(cntVal) - STEP)); // R3

  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck && !memErr) |=> (srcVal == $past(srcVal) + STEP)); // R3

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|{statusWord[ST_MEM], statusWord[ST_ALIGN], statusWord[ST_TYPE], statusWord[ST_SIZE]})
    |-> !statusWord[ST_BUSY]); // R10

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusWord[ST_EOT] || statusWord[ST_MEM] || statusWord[ST_ALIGN] ||
             statusWord[ST_TYPE] || statusWord[ST_SIZE])); // R7

endmodule

bind desc_dma_chan dma_chan_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAck    (memAck),
  .memErr    (memErr),
  .memAddr   (memAddr),
  .irq       (irq),
  .statusWord(statusWord),
  .cntVal    (cntVal),
  .srcVal    (srcVal)
);

// File: tb/test_desc_dma_chan.sv
`timescale 1ns/1ps
module test_desc_dma_chan;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        memErr = 1'b0;
  logic        irq;

  logic [31:0] mem [0:1023];
  logic        tbWe = 1'b0;
  logic [31:0] tbAddr = '0, tbData = '0;
  logic [31:0] errAddr = 32'hFFFF_FFFC;
  int          accTotal = 0;
  int          holdViol = 0;
  logic        prevPend = 1'b0;
  logic [31:0] prevAddr = '0;
  int          errors = 0, checks = 0;
  int          accBase;

  always #5 clk = ~clk;

  desc_dma_chan i_desc_dma_chan (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .memErr(memErr), .irq(irq)
  );

  // memory model: acknowledge one cycle after a request is seen
  always @(posedge clk) begin
    if (tbWe) mem[tbAddr[11:2]] <= tbData;
    memAck <= memReq && !memAck;
    memErr <= memReq && !memAck && (memAddr == errAddr);
    if (memReq && !memAck) begin
      accTotal <= accTotal + 1;
      memRdata <= mem[memAddr[11:2]];
      if (memWe && memAddr != errAddr) mem[memAddr[11:2]] <= memWdata;
    end
    if (prevPend && (!memReq || memAddr != prevAddr)) holdViol <= holdViol + 1;
    prevPend <= memReq && !memAck;
    prevAddr <= memAddr;
  end

  initial begin
    #2_000_000;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic setDesc(input logic [31:0] base, input logic [31:0] nxt, input logic [31:0] src,
                         input logic [31:0] usrc, input logic [31:0] dst,
                         input logic [31:0] cnt, input logic [31:0] ctl);
    poke(base, nxt);
    poke(base + 4, src);
    poke(base + 8, usrc);
    poke(base + 12, dst);
    poke(base + 16, cnt);
    poke(base + 20, ctl);
    poke(base + 24, 32'h0);
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rdReg(8'h04, v);
      if (!v[10]) break;
    end
  endtask

  task automatic startChain(input logic [31:0] base);
    wrReg(8'h00, 32'h0);
    wrReg(8'h10, base);
    wrReg(8'h04, 32'hFFFF_FFFF);
    @(negedge clk);
    accBase = accTotal;
    wrReg(8'h00, 32'h1);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rdReg(8'h00, v); chk("R1 control", v, 32'h0);
    rdReg(8'h04, v); chk("R1 status", v, 32'h0);
    rdReg(8'h0C, v); chk("R1 current", v, 32'h0);
    rdReg(8'h20, v); chk("R1 count", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 memReq", {31'b0, memReq}, 32'h0);
  endtask

  task automatic testSingle();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) poke(32'h400 + 4 * i, 32'hA500_0000 + i);
    for (int i = 0; i < 4; i++) poke(32'h800 + 4 * i, 32'h0);
    setDesc(32'h100, 32'h0, 32'h400, 32'h55, 32'h800, 32'd16, 32'h5E);
    startChain(32'h100);
    rdReg(8'h04, v); chk("R5 busy while working", {31'b0, v[10]}, 32'h1);
    waitIdle();
    for (int i = 0; i < 4; i++) chk("R3 copied word", mem[10'h200 + i], 32'hA500_0000 + i);
    rdReg(8'h04, v); chk("R4 R6 status after single", v, 32'h300);
    chk("R6 irq with intEn", {31'b0, irq}, 32'h1);
    rdReg(8'h0C, v); chk("R2 current desc", v, 32'h100);
    rdReg(8'h18, v); chk("R2 upper source field", v, 32'h55);
    rdReg(8'h24, v); chk("R2 control field", v, 32'h5E);
    rdReg(8'h14, v); chk("R3 source advanced", v, 32'h410);
    rdReg(8'h1C, v); chk("R3 dest advanced", v, 32'h810);
    rdReg(8'h20, v); chk("R3 count drained", v, 32'h0);
    chk("R2 R3 access count", accTotal - accBase, 32'd15);
  endtask

  task automatic testClear();
    logic [31:0] v;
    wrReg(8'h04, 32'h0);
    rdReg(8'h04, v); chk("R7 zero write keeps flags", v, 32'h300);
    wrReg(8'h04, 32'h200);
    rdReg(8'h04, v); chk("R7 clear eot only", v, 32'h100);
    chk("R7 irq withdrawn", {31'b0, irq}, 32'h0);
    wrReg(8'h04, 32'h100);
    rdReg(8'h04, v); chk("R7 clear eoc", v, 32'h0);
  endtask

  task automatic testChain();
    logic [31:0] v;
    setDesc(32'h140, 32'h180, 32'h400, 32'h0, 32'h900, 32'd8, 32'h4E);
    setDesc(32'h180, 32'h0, 32'h400, 32'h0, 32'h980, 32'd0, 32'h4E);
    startChain(32'h140);
    waitIdle();
    chk("R4 chain word0", mem[10'h240], 32'hA500_0000);
    chk("R4 chain word1", mem[10'h241], 32'hA500_0001);
    rdReg(8'h0C, v); chk("R4 followed link", v, 32'h180);
    rdReg(8'h04, v); chk("R4 chain status", v, 32'h300);
    chk("R6 no irq without intEn", {31'b0, irq}, 32'h0);
    chk("R8 zero count no data access", accTotal - accBase, 32'd18);
  endtask

  task automatic testAppendIdle();
    logic [31:0] v;
    wrReg(8'h04, 32'hFFFF_FFFF);
    setDesc(32'h1C0, 32'h0, 32'h0, 32'h0, 32'h0, 32'd0, 32'h5E);
    poke(32'h180, 32'h1C0);
    @(negedge clk);
    accBase = accTotal;
    wrReg(8'h00, 32'h3);
    waitIdle();
    rdReg(8'h0C, v); chk("R9 resumed at appended desc", v, 32'h1C0);
    chk("R9 R8 reread plus fetch only", accTotal - accBase, 32'd8);
    rdReg(8'h04, v); chk("R9 status after append", v, 32'h300);
    chk("R8 interrupt-only descriptor irq", {31'b0, irq}, 32'h1);
    rdReg(8'h00, v); chk("R9 append bit reads 0", v, 32'h1);
  endtask

  task automatic testValidate();
    logic [31:0] v;
    setDesc(32'h200, 32'h0, 32'h400, 32'h0, 32'hA00, 32'h0100_0004, 32'h0E);
    startChain(32'h200);
    waitIdle();
    rdReg(8'h04, v); chk("R10 oversize wins priority", v, 32'h002);
    rdReg(8'h00, v); chk("R10 enable cleared", v, 32'h0);
    chk("R10 no data access", accTotal - accBase, 32'd7);
    chk("R10 error irq", {31'b0, irq}, 32'h1);
    setDesc(32'h200, 32'h0, 32'h400, 32'h0, 32'hA00, 32'd8, 32'h0E);
    startChain(32'h200);
    waitIdle();
    rdReg(8'h04, v); chk("R10 type error", v, 32'h004);
    setDesc(32'h200, 32'h0, 32'h402, 32'h0, 32'hA00, 32'd8, 32'h4E);
    startChain(32'h200);
    waitIdle();
    rdReg(8'h04, v); chk("R10 align error", v, 32'h008);
  endtask

  task automatic testMemErr();
    logic [31:0] v;
    poke(32'hA00, 32'h0);
    poke(32'hA04, 32'h1234);
    setDesc(32'h200, 32'h0, 32'h400, 32'h0, 32'hA00, 32'd8, 32'h4E);
    errAddr = 32'h404;
    startChain(32'h200);
    waitIdle();
    errAddr = 32'hFFFF_FFFC;
    rdReg(8'h04, v); chk("R11 mem error flag", v, 32'h020);
    rdReg(8'h00, v); chk("R11 enable cleared", v, 32'h0);
    chk("R11 stopped at faulting access", accTotal - accBase, 32'd10);
    chk("R11 first word written", mem[10'h280], 32'hA500_0000);
    chk("R11 second word untouched", mem[10'h281], 32'h1234);
    chk("R11 irq", {31'b0, irq}, 32'h1);
  endtask

  task automatic testDisable();
    logic [31:0] v;
    poke(32'hC00, 32'hDEAD);
    setDesc(32'h240, 32'h280, 32'h400, 32'h0, 32'hB00, 32'd64, 32'h4E);
    setDesc(32'h280, 32'h0, 32'h400, 32'h0, 32'hC00, 32'd8, 32'h4E);
    startChain(32'h240);
    repeat (20) @(negedge clk);
    wrReg(8'h00, 32'h0);
    waitIdle();
    for (int i = 0; i < 16; i++) chk("R12 current finished", mem[10'h2C0 + i], 32'hA500_0000 + i);
    chk("R12 next not followed", mem[10'h300], 32'hDEAD);
    rdReg(8'h0C, v); chk("R12 current desc", v, 32'h240);
    rdReg(8'h04, v); chk("R12 eot without eoc", v, 32'h200);
  endtask

  task automatic testAppendBusy();
    logic [31:0] v;
    setDesc(32'h2C0, 32'h0, 32'h400, 32'h0, 32'hD00, 32'd16, 32'h4E);
    setDesc(32'h300, 32'h0, 32'h0, 32'h0, 32'h0, 32'd0, 32'h5E);
    startChain(32'h2C0);
    repeat (10) @(negedge clk);
    poke(32'h2C0, 32'h300);
    wrReg(8'h00, 32'h3);
    waitIdle();
    rdReg(8'h0C, v); chk("R9 posted append followed", v, 32'h300);
    chk("R9 posted append accesses", accTotal - accBase, 32'd23);
    rdReg(8'h04, v); chk("R9 status after posted append", v, 32'h300);
    chk("R9 irq from appended desc", {31'b0, irq}, 32'h1);
  endtask

  task automatic testNullStart();
    logic [31:0] v;
    startChain(32'h0);
    waitIdle();
    rdReg(8'h04, v); chk("R4 null start sets eoc", v, 32'h100);
    chk("R4 null start no access", accTotal - accBase, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSingle();
    testClear();
    testChain();
    testAppendIdle();
    testValidate();
    testMemErr();
    testDisable();
    testAppendBusy();
    testNullStart();
    chk("R13 request held until ack", holdViol, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule